// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block is the presentation stage that sits between an interrupt source layer and a single processor. It holds a control word with two fields. The upper field is the priority level the processor currently runs at. The lower field is the number of the source that waits for the processor. Beside the word it keeps the priority of the waiting source and a software-written priority for a built-in inter-processor interrupt. Smaller priority numbers are more favoured. The value 0xFF means "off".

The source layer offers requests, each a source number with a priority. The presenter either latches a request and raises the processor interrupt line, or it hands the request straight back as a reject. A waiting source that a better request, a tighter processor level or the inter-processor interrupt pushes aside is also handed back as a reject. Software acts through four operations: take the waiting interrupt, signal end of service, set the processor level, and set the inter-processor priority. The presenter answers with single-cycle pulses to the source layer: reject with a source number, end-of-service with a source number, and a request to re-offer held-back interrupts.

Top module: `intr_presenter`

## Requirements
- R1: After a synchronous reset, `cur_word` is zero, `cpu_irq` is low, no pulse is raised, `acc_word` is zero and the inter-processor priority is 0xFF.
- R2: `cur_word[31:24]` is the processor level and `cur_word[23:0]` is the waiting source number, where zero means nothing waits. `cpu_irq` is high exactly when a source waits.
- R3: A request is rejected back (a one-cycle `rej_valid` carrying its `req_src`) when its priority is numerically at or above the processor level, or when a waiting source has a priority at or below the request's priority. `rej_valid`, `eoi_valid` and `resend_req` are each high for one cycle per event and low otherwise.
- R4: A request that passes the screen becomes the waiting source with its priority. Any source that waited before is rejected in the same cycle.
- R5: The take operation (`op_code` 0) loads `acc_word` with the control word as it stood before the operation. The level becomes the old waiting priority, the source field clears, the waiting priority returns to 0xFF and `cpu_irq` falls.
- R6: The set-level operation (`op_code` 2, value in `op_data[7:0]`) stores the level. When the new level is smaller than the old one and a waiting source has a priority at or above the new level, that source is cleared and rejected.
- R7: A set-level operation whose value is not below the old level, with nothing waiting, pulses `resend_req`. If the inter-processor priority is then below the new level, the inter-processor source is loaded.
- R8: The set-IPI operation (`op_code` 3, value in `op_data[7:0]`) stores the inter-processor priority. When that priority is below the current level and no waiting source has a priority at or below it, any waiting source is rejected, source number `IPI_SRC` (default 2) is loaded with that priority, and `cpu_irq` rises.
- R9: The end-of-service operation (`op_code` 1) copies `op_data[31:24]` into the level and pulses `eoi_valid` with `op_data[23:0]`. With nothing waiting, it also pulses `resend_req` and loads the inter-processor source when its priority is below the new level.
- R10: A request presented in the same cycle as an operation is ignored: it is neither latched nor rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Source layer offers a request |
| req_src | input | 24 | Source number of the offered request |
| req_prio | input | 8 | Priority of the offered request |
| op_valid | input | 1 | Software operation this cycle |
| op_code | input | 2 | 0 take, 1 end of service, 2 set level, 3 set IPI priority |
| op_data | input | 32 | Operation operand |
| cpu_irq | output | 1 | Interrupt line to the processor |
| cur_word | output | 32 | Control word: level and waiting source |
| acc_word | output | 32 | Word returned by the last take |
| rej_valid | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Source number being rejected |
| eoi_valid | output | 1 | End-of-service pulse to the source layer |
| eoi_src | output | 24 | Source number whose service ended |
| resend_req | output | 1 | Ask the source layer to re-offer held interrupts |

## Verification
The bench builds the block with its default values: 8-bit priorities, 24-bit source numbers and inter-processor source 2. Random priorities are drawn from a narrow set of 0 to 6 plus 0xFF. This narrow set makes equal priorities frequent, so the at-or-below comparisons in the screen, the level clear and the inter-processor check are exercised in both directions. The off value exercises the cases where the inter-processor interrupt can never fire.

// File: rtl/pres_pkg.sv
package pres_pkg;

    parameter int PRIO_W = 8;
    parameter int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

    typedef enum logic [1:0] {
        OP_TAKE  = 2'd0,
        OP_DONE  = 2'd1,
        OP_LEVEL = 2'd2,
        OP_IPI   = 2'd3
    } op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] level;
        logic [SRC_W-1:0]  src;
    } ctl_word_t;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } src_msg_t;

    function automatic logic favours(input logic [PRIO_W-1:0] a,
                                     input logic [PRIO_W-1:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/pres_req_screen.sv
module pres_req_screen
    import pres_pkg::*;
(
    input  logic [PRIO_W-1:0] level,
    input  logic              has_pend,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] req_prio,
    output logic              take,
    output logic              displace
);
    logic blocked;

    always_comb begin
        blocked  = has_pend && !favours(req_prio, pend_prio);
        take     = favours(req_prio, level) && !blocked;
        displace = take && has_pend;
    end
endmodule

// File: rtl/pres_ipi_eval.sv
module pres_ipi_eval
    import pres_pkg::*;
(
    input  logic [PRIO_W-1:0] level,
    input  logic              has_pend,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] ipi_prio,
    output logic              fire,
    output logic              displace
);
    logic held_off;

    always_comb begin
        held_off = has_pend && !favours(ipi_prio, pend_prio);
        fire     = favours(ipi_prio, level) && !held_off;
        displace = fire && has_pend;
    end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
    import pres_pkg::*;
#(
    parameter int IPI_SRC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [WORD_W-1:0] op_data,
    output logic              cpu_irq,
    output logic [WORD_W-1:0] cur_word,
    output logic [WORD_W-1:0] acc_word,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_req
);
    localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

    ctl_word_t         cur_q, cur_d;
    logic [PRIO_W-1:0] pend_q, pend_d;
    logic [PRIO_W-1:0] ipi_q, ipi_d;
    logic [WORD_W-1:0] acc_q, acc_d;
    src_msg_t          rej_q, rej_d, eoi_q, eoi_d;
    logic              rs_q, rs_d;

    op_e               op;
    logic              has_pend;
    logic [PRIO_W-1:0] op_prio;
    logic [PRIO_W-1:0] op_level;
    logic              scr_take, scr_disp;
    logic [PRIO_W-1:0] ipi_cand, ipi_lvl;
    logic              ipi_fire, ipi_disp;

    assign op       = op_e'(op_code);
    assign has_pend = (cur_q.src != '0);
    assign op_prio  = op_data[PRIO_W-1:0];
    assign op_level = op_data[WORD_W-1 -: PRIO_W];

    // One evaluator serves both the IPI write and the resend path
    assign ipi_cand = (op == OP_IPI) ? op_prio : ipi_q;
    always_comb begin
        case (op)
            OP_IPI:   ipi_lvl = cur_q.level;
            OP_LEVEL: ipi_lvl = op_prio;
            OP_DONE:  ipi_lvl = op_level;
            default:  ipi_lvl = cur_q.level;
        endcase
    end

    pres_req_screen u_screen (
        .level    (cur_q.level),
        .has_pend (has_pend),
        .pend_prio(pend_q),
        .req_prio (req_prio),
        .take     (scr_take),
        .displace (scr_disp)
    );

    pres_ipi_eval u_ipi (
        .level    (ipi_lvl),
        .has_pend (has_pend),
        .pend_prio(pend_q),
        .ipi_prio (ipi_cand),
        .fire     (ipi_fire),
        .displace (ipi_disp)
    );

    always_comb begin
        cur_d  = cur_q;
        pend_d = pend_q;
        ipi_d  = ipi_q;
        acc_d  = acc_q;
        rej_d  = '0;
        eoi_d  = '0;
        rs_d   = 1'b0;
        if (op_valid) begin
            case (op)
                OP_TAKE: begin
                    acc_d     = cur_q;
                    cur_d.level = pend_q;
                    cur_d.src = '0;
                    pend_d    = PRIO_OFF;
                end
                OP_LEVEL: begin
                    cur_d.level = op_prio;
                    if (favours(op_prio, cur_q.level)) begin
                        if (has_pend && !favours(pend_q, op_prio)) begin
                            cur_d.src = '0;
                            pend_d    = PRIO_OFF;
                            rej_d     = '{valid: 1'b1, src: cur_q.src};
                        end
                    end else if (!has_pend) begin
                        rs_d = 1'b1;
                        if (ipi_fire) begin
                            cur_d.src = IPI_NUM;
                            pend_d    = ipi_q;
                        end
                    end
                end
                OP_IPI: begin
                    ipi_d = op_prio;
                    if (ipi_fire) begin
                        if (ipi_disp) rej_d = '{valid: 1'b1, src: cur_q.src};
                        cur_d.src = IPI_NUM;
                        pend_d    = op_prio;
                    end
                end
                default: begin
                    cur_d.level = op_level;
                    eoi_d       = '{valid: 1'b1, src: op_data[SRC_W-1:0]};
                    if (!has_pend) begin
                        rs_d = 1'b1;
                        if (ipi_fire) begin
                            cur_d.src = IPI_NUM;
                            pend_d    = ipi_q;
                        end
                    end
                end
            endcase
        end else if (req_valid) begin
            if (scr_take) begin
                if (scr_disp) rej_d = '{valid: 1'b1, src: cur_q.src};
                cur_d.src = req_src;
                pend_d    = req_prio;
            end else begin
                rej_d = '{valid: 1'b1, src: req_src};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            pend_q <= PRIO_OFF;
            ipi_q  <= PRIO_OFF;
            acc_q  <= '0;
            rej_q  <= '0;
            eoi_q  <= '0;
            rs_q   <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            pend_q <= pend_d;
            ipi_q  <= ipi_d;
            acc_q  <= acc_d;
            rej_q  <= rej_d;
            eoi_q  <= eoi_d;
            rs_q   <= rs_d;
        end
    end

    assign cur_word   = cur_q;
    assign cpu_irq    = has_pend;
    assign acc_word   = acc_q;
    assign rej_valid  = rej_q.valid;
    assign rej_src    = rej_q.src;
    assign eoi_valid  = eoi_q.valid;
    assign eoi_src    = eoi_q.src;
    assign resend_req = rs_q;

    AST_TAKE_DROPS_LINE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0) |=> (!cpu_irq && cur_word[SRC_W-1:0] == '0)); // R5
    AST_TAKE_RETURNS_WORD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0) |=> (acc_word == $past(cur_word))); // R5
    AST_LOW_REQ_BOUNCES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !op_valid && req_prio >= cur_word[WORD_W-1 -: PRIO_W])
        |=> (rej_valid && rej_src == $past(req_src))); // R3
    AST_DONE_FORWARDS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd1)
        |=> (eoi_valid && eoi_src == $past(op_data[SRC_W-1:0])
             && cur_word[WORD_W-1 -: PRIO_W] == $past(op_data[WORD_W-1 -: PRIO_W]))); // R9
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd2)
        |=> (cur_word[WORD_W-1 -: PRIO_W] == $past(op_data[PRIO_W-1:0]))); // R6
    AST_NO_EOI_WITHOUT_OP: assert property (@(posedge clk) disable iff (rst)
        (!op_valid) |=> !eoi_valid); // R3

endmodule

// File: tb/intr_presenter_tb.sv
`timescale 1ns/100ps
module intr_presenter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = '0;
    logic [7:0]  req_prio = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic [31:0] op_data = '0;
    logic        cpu_irq, rej_valid, eoi_valid, resend_req;
    logic [31:0] cur_word, acc_word;
    logic [23:0] rej_src, eoi_src;

    int checks = 0;
    int fails  = 0;

    // reference state built from the requirements
    logic [7:0]  m_lvl, m_pend, m_ipi;
    logic [23:0] m_src;
    logic [31:0] m_acc;
    logic        e_rej, e_eoi, e_rs;
    logic [23:0] e_rej_src, e_eoi_src;
    string       tag;

    always #2.5 clk = ~clk;

    intr_presenter u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
        .req_prio(req_prio), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .cpu_irq(cpu_irq), .cur_word(cur_word),
        .acc_word(acc_word), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    task automatic check(input string t, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic ipi_load();
        m_src  = 24'd2;
        m_pend = m_ipi;
    endtask

    task automatic model(input logic ov, input logic [1:0] oc, input logic [31:0] od,
                         input logic rv, input logic [23:0] rs, input logic [7:0] rp);
        logic pend;
        pend  = (m_src != 0);
        e_rej = 0; e_eoi = 0; e_rs = 0; e_rej_src = 0; e_eoi_src = 0;
        tag   = "R10 idle";
        if (ov) begin
            case (oc)
                2'd0: begin
                    tag = "R5 take";
                    m_acc = {m_lvl, m_src};
                    m_lvl = m_pend; m_src = 0; m_pend = 8'hFF;
                end
                2'd2: begin
                    if (od[7:0] < m_lvl) begin
                        tag = "R6 level-down";
                        if (pend && od[7:0] <= m_pend) begin
                            e_rej = 1; e_rej_src = m_src; m_src = 0; m_pend = 8'hFF;
                        end
                        m_lvl = od[7:0];
                    end else begin
                        tag = "R7 level-up";
                        m_lvl = od[7:0];
                        if (!pend) begin
                            e_rs = 1;
                            if (m_ipi < m_lvl) ipi_load();
                        end
                    end
                end
                2'd3: begin
                    tag = "R8 ipi";
                    m_ipi = od[7:0];
                    if (m_ipi < m_lvl && !(pend && m_pend <= m_ipi)) begin
                        if (pend) begin e_rej = 1; e_rej_src = m_src; end
                        ipi_load();
                    end
                end
                default: begin
                    tag = "R9 eoi";
                    m_lvl = od[31:24];
                    e_eoi = 1; e_eoi_src = od[23:0];
                    if (!pend) begin
                        e_rs = 1;
                        if (m_ipi < m_lvl) ipi_load();
                    end
                end
            endcase
            if (rv) tag = {tag, " R10"};
        end else if (rv) begin
            if (rp >= m_lvl || (pend && m_pend <= rp)) begin
                tag = "R3 screen";
                e_rej = 1; e_rej_src = rs;
            end else begin
                tag = "R4 R2 latch";
                if (pend) begin e_rej = 1; e_rej_src = m_src; end
                m_src = rs; m_pend = rp;
            end
        end
    endtask

    task automatic step(input logic ov, input logic [1:0] oc, input logic [31:0] od,
                        input logic rv, input logic [23:0] rs, input logic [7:0] rp);
        op_valid = ov; op_code = oc; op_data = od;
        req_valid = rv; req_src = rs; req_prio = rp;
        model(ov, oc, od, rv, rs, rp);
        @(posedge clk);
        @(negedge clk);
        check({tag, " word/irq"}, {63'd0, cur_word, acc_word, cpu_irq},
              {63'd0, m_lvl, m_src, m_acc, (m_src != 0)});
        check({tag, " pulses"},
              {77'd0, rej_valid, (rej_valid ? rej_src : 24'd0), eoi_valid,
               (eoi_valid ? eoi_src : 24'd0), resend_req},
              {77'd0, e_rej, e_rej_src, e_eoi, e_eoi_src, e_rs});
    endtask

    function automatic logic [7:0] rprio();
        logic [2:0] v;
        v = 3'($urandom % 8);
        return (v == 3'd7) ? 8'hFF : {5'd0, v};
    endfunction

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_lvl = 0; m_src = 0; m_pend = 8'hFF; m_ipi = 8'hFF; m_acc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset word", {cur_word, acc_word}, 64'd0);
        check("R1 reset lines", {cpu_irq, rej_valid, eoi_valid, resend_req}, 4'd0);
        // directed corner cases
        step(0, 2'd0, 0, 1, 24'd7, 8'd3);                // R3 level 0 refuses all
        step(1, 2'd1, {8'h10, 24'd9}, 0, 0, 0);          // R9, R1 ipi off: no IPI load
        step(0, 2'd0, 0, 1, 24'd7, 8'd5);                // R4 latch
        step(0, 2'd0, 0, 1, 24'd8, 8'd5);                // R3 equal to waiting
        step(0, 2'd0, 0, 1, 24'd9, 8'd3);                // R4 displaces 7
        step(1, 2'd3, 32'hFF, 1, 24'd11, 8'd1);          // R10 request ignored
        step(1, 2'd0, 0, 0, 0, 0);                       // R5 take
        step(1, 2'd2, 32'h20, 0, 0, 0);                  // R7 resend, no IPI
        step(1, 2'd3, 32'h04, 0, 0, 0);                  // R8 IPI loads
        step(1, 2'd2, 32'h04, 0, 0, 0);                  // R6 clear at equal
        step(1, 2'd2, 32'h06, 0, 0, 0);                  // R7 resend loads IPI
        step(1, 2'd3, 32'h05, 0, 0, 0);                  // R8 held off by waiting
        step(1, 2'd1, {8'h03, 24'd2}, 0, 0, 0);          // R9 with waiting source
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic        ov;
            logic [1:0]  oc;
            logic [31:0] od;
            ov = ($urandom % 5) < 2;
            oc = 2'($urandom % 4);
            od = (oc == 2'd1) ? {rprio(), 24'($urandom % 12)} : {24'd0, rprio()};
            step(ov, oc, od, ($urandom % 4) != 0, 24'(3 + $urandom % 20), rprio());
        end
        step(0, 2'd0, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule